// File: doc/BRIEF.md
# Integer ALU with Sticky Overflow Flags

This unit computes a 32-bit result in the same cycle its operands arrive and keeps a small set of status flags in registers. It supports addition, subtraction, a signed multiply that keeps only the low word of the product, and a conditional addition. The conditional addition commits only when a condition operand tests non-zero, or zero when the inverted polarity is chosen. With each committed operation the unit records a signed overflow flag and an advanced overflow flag. The advanced overflow flag shows whether the top two result bits differ. Each of these two flags also has a sticky copy that accumulates until software clears it.

The result and a write-enable are combinational outputs. A register file next to the unit uses the write-enable to decide whether the destination is written. The flags are written on the rising clock edge when a valid strobe accompanies an operation that commits. The flags are also assembled into a 32-bit status word at fixed bit positions, and the word's other bits hold constant values.

Top module: `ovf_alu`

## Requirements
- R1: With op_i = 0 (add), res_o is a_i + b_i modulo 2^32, and V is set exactly when the signed sum does not fit in 32 bits.
- R2: With op_i = 1 (subtract), res_o is a_i - b_i modulo 2^32, and V is set exactly when the signed difference does not fit in 32 bits.
- R3: With op_i = 2 (multiply), res_o is the low 32 bits of the signed 64-bit product, and V is set exactly when the high 32 bits differ from 32 copies of res_o bit 31.
- R4: On every committed operation, av_o becomes res_o[31] XOR res_o[30] of that operation's result.
- R5: On every committed operation, sv_o becomes sv_o OR V and sav_o becomes sav_o OR AV, so an operation without overflow never clears a sticky flag.
- R6: With op_i = 3 (conditional add), the operation commits when cond_neg_i = 0 and cond_i != 0, or when cond_neg_i = 1 and cond_i == 0. A committed conditional add asserts wr_en_o and updates all four flags as an add does.
- R7: A conditional add that does not commit drives wr_en_o low and leaves v_o, av_o, sv_o and sav_o unchanged.
- R8: The flags change only on a rising clock edge with valid_i high and a committing operation. In any other cycle, including one with valid_i low, they hold.
- R9: clr_sticky_i synchronously clears sv_o and sav_o. If an operation commits in the same cycle, the sticky flags take that operation's V and AV alone.
- R10: While rst_ni is low, all four flags are 0 and stat_o reads 0x00000B80.
- R11: stat_o has bit 31 = 0, bit 30 = V, bit 29 = SV, bit 28 = AV, bit 27 = SAV, and bits 26:0 = 0xB80.
- R12: For add, subtract and multiply, wr_en_o equals valid_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 2 | Operation select: 0 add, 1 subtract, 2 multiply, 3 conditional add |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| cond_i | input | 32 | Condition operand for the conditional add |
| cond_neg_i | input | 1 | 0: commit when cond_i is non-zero; 1: commit when cond_i is zero |
| clr_sticky_i | input | 1 | Synchronous clear of the sticky flags |
| res_o | output | 32 | Result |
| wr_en_o | output | 1 | Destination write-enable |
| v_o | output | 1 | Overflow flag |
| sv_o | output | 1 | Sticky overflow flag |
| av_o | output | 1 | Advanced overflow flag |
| sav_o | output | 1 | Sticky advanced overflow flag |
| stat_o | output | 32 | Status word with the flags at fixed positions |

## Verification
The only state in the unit is the four flag bits, so any internal fault shows up in v_o, av_o, sv_o, sav_o and the matching stat_o bits one edge after the operation that caused it. A sticky flag that clears itself, or that fails to set, stays wrong at the ports until the next clear, and this makes an error there long-lived but easy to see. A broken commit condition in the conditional add shows in the same cycle on wr_en_o, and one edge later as flags that moved when they should have held. Result errors are purely combinational and appear on res_o in the cycle the operands are applied.

// File: rtl/ovf_alu_pkg.sv
package ovf_alu_pkg;

  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_SUB  = 2'd1,
    OP_MUL  = 2'd2,
    OP_CADD = 2'd3
  } alu_op_e;

  typedef struct packed {
    logic v;
    logic sv;
    logic av;
    logic sav;
  } flags_t;

  localparam int unsigned STAT_LOW_W = 12;
  localparam logic [STAT_LOW_W-1:0] STAT_LOW = 12'hB80;

endpackage

// File: rtl/ovf_alu_addsub.sv
module ovf_alu_addsub #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         v_o
);
  logic [W-1:0] b_eff;
  logic [W-1:0] sum;

  assign b_eff = sub_i ? ~b_i : b_i;
  assign sum   = a_i + b_eff + {{(W-1){1'b0}}, sub_i};

  // overflow: result sign departs from a; operand signs agree (add) or differ (sub)
  always_comb begin
    if (sub_i) v_o = (sum[W-1] ^ a_i[W-1]) &  (a_i[W-1] ^ b_i[W-1]);
    else       v_o = (sum[W-1] ^ a_i[W-1]) & ~(a_i[W-1] ^ b_i[W-1]);
  end

  assign sum_o = sum;
endmodule

// File: rtl/ovf_alu_mul.sv
module ovf_alu_mul #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] lo_o,
  output logic         v_o
);
  localparam int unsigned PW = 2 * W;

  logic [PW-1:0] a_ext, b_ext, prod;

  assign a_ext = {{W{a_i[W-1]}}, a_i};
  assign b_ext = {{W{b_i[W-1]}}, b_i};
  assign prod  = a_ext * b_ext;

  assign lo_o = prod[W-1:0];
  assign v_o  = prod[PW-1:W] != {W{prod[W-1]}};
endmodule

// File: rtl/ovf_alu_flags.sv
module ovf_alu_flags
  import ovf_alu_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       upd_i,
  input  logic       clr_i,
  input  logic       v_i,
  input  logic [1:0] res_top_i,
  output flags_t     flags_o
);
  flags_t q;
  logic   av_new;

  assign av_new = res_top_i[1] ^ res_top_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= '0;
    end else begin
      if (upd_i) begin
        q.v  <= v_i;
        q.av <= av_new;
      end
      // clear first, then fold in the committing operation
      q.sv  <= (q.sv  & ~clr_i) | (upd_i & v_i);
      q.sav <= (q.sav & ~clr_i) | (upd_i & av_new);
    end
  end

  assign flags_o = q;
endmodule

// File: rtl/ovf_alu.sv
module ovf_alu
  import ovf_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] cond_i,
  input  logic              cond_neg_i,
  input  logic              clr_sticky_i,
  output logic [DATA_W-1:0] res_o,
  output logic              wr_en_o,
  output logic              v_o,
  output logic              sv_o,
  output logic              av_o,
  output logic              sav_o,
  output logic [DATA_W-1:0] stat_o
);
  localparam int unsigned PAD_W = DATA_W - 5 - STAT_LOW_W;

  alu_op_e           op;
  logic [DATA_W-1:0] as_sum, mul_lo;
  logic              as_v, mul_v;
  logic              cond_true, commit;
  logic              v_sel;
  flags_t            flags;

  assign op = alu_op_e'(op_i);

  ovf_alu_addsub #(.W(DATA_W)) u_addsub (
    .a_i   (a_i),
    .b_i   (b_i),
    .sub_i (op == OP_SUB),
    .sum_o (as_sum),
    .v_o   (as_v)
  );

  ovf_alu_mul #(.W(DATA_W)) u_mul (
    .a_i  (a_i),
    .b_i  (b_i),
    .lo_o (mul_lo),
    .v_o  (mul_v)
  );

  assign cond_true = cond_neg_i ? (cond_i == '0) : (cond_i != '0);
  assign commit    = valid_i & ((op != OP_CADD) | cond_true);

  always_comb begin
    if (op == OP_MUL) begin
      res_o = mul_lo;
      v_sel = mul_v;
    end else begin
      res_o = as_sum;
      v_sel = as_v;
    end
  end

  ovf_alu_flags u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .upd_i     (commit),
    .clr_i     (clr_sticky_i),
    .v_i       (v_sel),
    .res_top_i (res_o[DATA_W-1:DATA_W-2]),
    .flags_o   (flags)
  );

  assign wr_en_o = commit;
  assign v_o     = flags.v;
  assign sv_o    = flags.sv;
  assign av_o    = flags.av;
  assign sav_o   = flags.sav;
  assign stat_o  = {1'b0, flags.v, flags.sv, flags.av, flags.sav, {PAD_W{1'b0}}, STAT_LOW};
endmodule

// File: rtl/ovf_alu_chk.sv
module ovf_alu_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [1:0]        op_i,
  input logic [DATA_W-1:0] cond_i,
  input logic              cond_neg_i,
  input logic              clr_sticky_i,
  input logic [DATA_W-1:0] res_o,
  input logic              wr_en_o,
  input logic              v_o,
  input logic              sv_o,
  input logic              av_o,
  input logic              sav_o
);
  AST_AV_FROM_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni) (valid_i && wr_en_o) |=> av_o == ($past(res_o[DATA_W-1]) ^ $past(res_o[DATA_W-2]))); // R4
  AST_STICKY_COVERS: assert property (@(posedge clk_i) disable iff (!rst_ni) (valid_i && wr_en_o) |=> ((!v_o || sv_o) && (!av_o || sav_o))); // R5
  AST_STICKY_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni) (!clr_sticky_i && sv_o && sav_o) |=> (sv_o && sav_o)); // R5
  AST_CADD_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni) (valid_i && op_i == 2'd3 && (cond_neg_i ? (cond_i != '0) : (cond_i == '0))) |-> !wr_en_o); // R7
  AST_FLAGS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) !(valid_i && wr_en_o) |=> ($stable(v_o) && $stable(av_o))); // R8
  AST_CLEAR_ALONE: assert property (@(posedge clk_i) disable iff (!rst_ni) (clr_sticky_i && !(valid_i && wr_en_o)) |=> (!sv_o && !sav_o)); // R9
  AST_PLAIN_WREN: assert property (@(posedge clk_i) disable iff (!rst_ni) (op_i != 2'd3) |-> (wr_en_o == valid_i)); // R12
endmodule

bind ovf_alu ovf_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .valid_i      (valid_i),
  .op_i         (op_i),
  .cond_i       (cond_i),
  .cond_neg_i   (cond_neg_i),
  .clr_sticky_i (clr_sticky_i),
  .res_o        (res_o),
  .wr_en_o      (wr_en_o),
  .v_o          (v_o),
  .sv_o         (sv_o),
  .av_o         (av_o),
  .sav_o        (sav_o)
);

// File: tb/sim_ovf_alu.sv
`timescale 1ns/1ps
module sim_ovf_alu;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  op_i = 2'd0;
  logic [31:0] a_i = '0, b_i = '0, cond_i = '0;
  logic        cond_neg_i = 1'b0, clr_sticky_i = 1'b0;
  logic [31:0] res_o, stat_o;
  logic        wr_en_o, v_o, sv_o, av_o, sav_o;

  int total = 0;
  int bad = 0;
  logic m_v = 0, m_av = 0, m_sv = 0, m_sav = 0;

  always #2.5 clk = ~clk;

  ovf_alu u0 (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .cond_i(cond_i), .cond_neg_i(cond_neg_i),
    .clr_sticky_i(clr_sticky_i), .res_o(res_o), .wr_en_o(wr_en_o),
    .v_o(v_o), .sv_o(sv_o), .av_o(av_o), .sav_o(sav_o), .stat_o(stat_o)
  );

  // op, a, b, expected result, expected V
  localparam logic [98:0] VEC [0:10] = '{
    {2'd0, 32'h00000001, 32'h00000002, 32'h00000003, 1'b0},
    {2'd0, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b1},
    {2'd0, 32'h80000000, 32'h80000000, 32'h00000000, 1'b1},
    {2'd1, 32'h80000000, 32'h00000001, 32'h7FFFFFFF, 1'b1},
    {2'd1, 32'h00000005, 32'h00000007, 32'hFFFFFFFE, 1'b0},
    {2'd2, 32'h00000003, 32'hFFFFFFFE, 32'hFFFFFFFA, 1'b0},
    {2'd2, 32'h00010000, 32'h00010000, 32'h00000000, 1'b1},
    {2'd2, 32'h7FFFFFFF, 32'h00000002, 32'hFFFFFFFE, 1'b1},
    {2'd2, 32'h80000000, 32'hFFFFFFFF, 32'h80000000, 1'b1},
    {2'd2, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000001, 1'b0},
    {2'd0, 32'h40000000, 32'h00000000, 32'h40000000, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic void ref_op(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                                 output logic [31:0] r, output logic v);
    logic [32:0] s;
    longint p;
    case (op)
      2'd1: begin s = {a[31], a} - {b[31], b}; r = s[31:0]; v = s[32] != s[31]; end
      2'd2: begin
        p = longint'($signed(a)) * longint'($signed(b));
        r = p[31:0];
        v = p[63:32] != {32{p[31]}};
      end
      default: begin s = {a[31], a} + {b[31], b}; r = s[31:0]; v = s[32] != s[31]; end
    endcase
  endfunction

  function automatic string op_tag(input logic [1:0] op);
    case (op)
      2'd0: return "R1";
      2'd1: return "R2";
      2'd2: return "R3";
      default: return "R6";
    endcase
  endfunction

  // one operation: drive at negedge, check result before the edge, flags after it
  task automatic step(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                      input logic [31:0] c, input logic neg, input logic clr, input logic vld);
    logic [31:0] r;
    logic v, commit, av;
    @(negedge clk);
    op_i = op; a_i = a; b_i = b; cond_i = c; cond_neg_i = neg;
    clr_sticky_i = clr; valid_i = vld;
    #1;
    ref_op(op, a, b, r, v);
    av = r[31] ^ r[30];
    commit = vld && (op != 2'd3 || (neg ? (c == 0) : (c != 0)));
    chk(op_tag(op), res_o, r);
    chk(op == 2'd3 ? (commit ? "R6" : "R7") : "R12", {31'd0, wr_en_o}, {31'd0, commit});
    if (clr) begin m_sv = 0; m_sav = 0; end
    if (commit) begin m_v = v; m_av = av; m_sv = m_sv | v; m_sav = m_sav | av; end
    @(posedge clk);
    #1;
    chk(op_tag(op), {31'd0, v_o}, {31'd0, m_v});
    chk("R4", {31'd0, av_o}, {31'd0, m_av});
    chk(clr ? "R9" : "R5", {30'd0, sv_o, sav_o}, {30'd0, m_sv, m_sav});
    chk("R11", stat_o, {1'b0, m_v, m_sv, m_av, m_sav, 27'h0000B80});
  endtask

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [98:0] e;
    repeat (3) @(posedge clk);
    #1;
    chk("R10", stat_o, 32'h00000B80);
    chk("R10", {28'd0, v_o, sv_o, av_o, sav_o}, 32'd0);
    @(negedge clk);
    rst_ni = 1'b1;

    for (int i = 0; i < 11; i++) begin
      e = VEC[i];
      step(e[98:97], e[96:65], e[64:33], 32'd1, 1'b0, 1'b0, 1'b1);
      chk(op_tag(e[98:97]), res_o, e[32:1]);
      chk(op_tag(e[98:97]), {31'd0, v_o}, {31'd0, e[0]});
    end

    // sticky flags survive a clean operation (R5)
    step(2'd0, 32'd1, 32'd1, 32'd0, 1'b0, 1'b0, 1'b1);
    chk("R5", {30'd0, sv_o, sav_o}, 32'd3);
    // clear alone (R9)
    step(2'd0, 32'd0, 32'd0, 32'd0, 1'b0, 1'b1, 1'b0);
    chk("R9", {30'd0, sv_o, sav_o}, 32'd0);
    // conditional add, commit on non-zero (R6)
    step(2'd3, 32'h7FFFFFFF, 32'd1, 32'd5, 1'b0, 1'b0, 1'b1);
    chk("R6", {28'd0, v_o, sv_o, av_o, sav_o}, 32'hF);
    // conditional add blocked, operands would clear V (R7)
    step(2'd3, 32'd1, 32'd1, 32'd0, 1'b0, 1'b0, 1'b1);
    chk("R7", {28'd0, v_o, sv_o, av_o, sav_o}, 32'hF);
    // inverted polarity commits on zero (R6)
    step(2'd3, 32'd1, 32'd1, 32'd0, 1'b1, 1'b0, 1'b1);
    chk("R6", {28'd0, v_o, sv_o, av_o, sav_o}, 32'h5);
    // inverted polarity blocked on non-zero (R7)
    step(2'd3, 32'h7FFFFFFF, 32'd1, 32'd3, 1'b1, 1'b0, 1'b1);
    chk("R7", {28'd0, v_o, sv_o, av_o, sav_o}, 32'h5);
    // overflowing operands with valid low (R8)
    step(2'd2, 32'h7FFFFFFF, 32'h7FFFFFFF, 32'd0, 1'b0, 1'b0, 1'b0);
    chk("R8", {28'd0, v_o, sv_o, av_o, sav_o}, 32'h5);
    // clear together with an overflowing add (R9)
    step(2'd0, 32'h7FFFFFFF, 32'd1, 32'd0, 1'b0, 1'b1, 1'b1);
    chk("R9", {28'd0, v_o, sv_o, av_o, sav_o}, 32'hF);
    // clear together with a clean add (R9)
    step(2'd0, 32'd1, 32'd1, 32'd0, 1'b0, 1'b1, 1'b1);
    chk("R9", {28'd0, v_o, sv_o, av_o, sav_o}, 32'h0);

    for (int i = 0; i < 400; i++) begin
      logic [31:0] ra, rb, rc;
      logic [2:0] pick;
      pick = 3'($urandom_range(0, 7));
      ra = (pick == 0) ? 32'h7FFFFFFF : (pick == 1) ? 32'h80000000 : $urandom;
      rb = (pick == 2) ? 32'h80000000 : (pick == 3) ? 32'h7FFFFFFF : $urandom;
      rc = $urandom_range(0, 1) ? 32'd0 : $urandom;
      step(2'($urandom_range(0, 3)), ra, rb, rc, 1'($urandom_range(0, 1)),
           ($urandom_range(0, 9) == 0), ($urandom_range(0, 7) != 0));
    end

    @(negedge clk);
    valid_i = 1'b0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule